// File: doc/BRIEF.md
# External DMA Request Acceptance Controller

This block sits between an active-low external request pin and a DMA engine's bus-cycle sequencer. It turns pin activity into single transfer requests. The pin first passes through a synchronizer. The block then samples it on every rising clock edge while acceptance is open. A low sample latches a request, and the block holds that request until the engine has started activation and run its next bus cycle (the read).

Two activation modes are available:

- **Falling-edge mode:** the block re-arms only if the pin has been seen high at some point between the start of activation and the end of the write cycle. Failing that, it waits for a high sample before it opens again.
- **Low-level mode:** the block reopens after the dead cycle whatever the pin level is, so a pin that stays low yields back-to-back requests.

In both modes the read, write and dead cycles set a minimum spacing between the drop of one request and the next opening.

Software enables the block with a one-cycle set strobe and disables it with a clear strobe. The clear strobe, or a transfer-done indication from the engine, sends the block back to idle and discards any held request.

Top module: `dreq_accept`

## Requirements
- R1: While reset is asserted and after it is released, `xfer_req` and `accept_open` are both 0 until an enable strobe arrives.
- R2: `accept_open` rises on the clock edge that samples `en_set` high. A low pin level present before that strobe produces no request.
- R3: A low synchronized pin sample while `accept_open` is 1 sets `xfer_req` to 1 and closes acceptance. `xfer_req` then stays 1 even if the pin returns high.
- R4: `xfer_req` drops on the edge that samples the first `rd_cyc` pulse after an `act_start` pulse. A `rd_cyc` pulse that arrives before `act_start` is ignored.
- R5: In falling-edge mode (`mode_level`=0), if the synchronized pin is sampled high on any edge from the one after `act_start` through the `wr_cyc` edge, acceptance reopens on the edge that samples `dead_cyc`.
- R6: In falling-edge mode, if no high sample occurred in that window, acceptance stays closed after `dead_cyc`. It reopens on the edge after the first high synchronized sample.
- R7: In low-level mode (`mode_level`=1), acceptance reopens on the `dead_cyc` edge regardless of the pin. A pin that is still low then raises `xfer_req` again on the next edge.
- R8: Between the edge where `xfer_req` drops and the edge where acceptance reopens, at least two full clock cycles pass with acceptance closed, one for the write step and one for the dead step.
- R9: A pulse on `en_clr` or `xfer_done` returns the block to idle on that edge, from any state, clearing `xfer_req` and `accept_open`. `en_clr` takes priority over `en_set`.
- R10: The pin passes through a two-stage synchronizer. A pin that falls before edge k while acceptance is open gives `xfer_req`=1 after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | One-cycle strobe that enables acceptance |
| en_clr | input | 1 | One-cycle strobe that disables and aborts |
| xfer_done | input | 1 | Whole transfer finished; return to idle |
| mode_level | input | 1 | 1 selects low-level activation, 0 selects falling-edge activation |
| req_pin_n | input | 1 | Asynchronous active-low request pin |
| act_start | input | 1 | Engine begins activation for the held request |
| rd_cyc | input | 1 | Engine's read bus cycle |
| wr_cyc | input | 1 | Engine's write bus cycle |
| dead_cyc | input | 1 | Engine's dead cycle after the write |
| xfer_req | output | 1 | Held transfer request to the engine |
| accept_open | output | 1 | Pin sampling for a new request is open |

## Verification
The falling-edge sequence is run with the pin returning high during the transfer, so that acceptance reopens right after the dead cycle. It is run again with the pin held low throughout, which separates that case from the stall that waits for a high sample. The same held-low pattern is then repeated in low-level mode; there a correct design issues back-to-back requests, and mixing up the modes shows up at once. Further patterns cover a read before activation, a pin that goes low before the enable, and aborts by clear strobe and by transfer done while a request is held. Each one tells apart a design that latches early, drops a request early, or keeps a request after an abort.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPEN  = 3'd1,
    ST_HELD  = 3'd2,
    ST_ACT   = 3'd3,
    ST_XFER  = 3'd4,
    ST_DEAD  = 3'd5,
    ST_WAITH = 3'd6
  } acc_state_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dreq_rearm.sv
module dreq_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic watch,
  input  logic pin_s,
  output logic hi_seen
);
  logic hi_d;

  always_comb begin
    hi_d = hi_seen;
    if (clr)                hi_d = 1'b0;
    else if (watch && pin_s) hi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_seen <= 1'b0;
    else        hi_seen <= hi_d;
  end
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
  import dreq_pkg::*;
#(
  parameter int GAP_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic xfer_done,
  input  logic mode_level,
  input  logic pin_s,
  input  logic act_start,
  input  logic rd_cyc,
  input  logic wr_cyc,
  input  logic dead_cyc,
  input  logic hi_seen,
  output logic track_clr,
  output logic track_on,
  output logic xfer_req,
  output logic accept_open
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(2);

  acc_state_t state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic abort;
  logic busy;

  assign abort = en_clr | xfer_done;
  assign busy  = (state_q == ST_XFER) || (state_q == ST_DEAD) || (state_q == ST_WAITH);

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (en_set)   state_d = ST_OPEN;
        ST_OPEN:  if (!pin_s)   state_d = ST_HELD;
        ST_HELD:  if (act_start) state_d = ST_ACT;
        ST_ACT:   if (rd_cyc)   state_d = ST_XFER;
        ST_XFER:  if (wr_cyc)   state_d = ST_DEAD;
        ST_DEAD:  if (dead_cyc) state_d = (mode_level || hi_seen) ? ST_OPEN : ST_WAITH;
        ST_WAITH: if (pin_s)    state_d = ST_OPEN;
        default:                state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gap_d = gap_q;
    if ((state_q == ST_ACT) && (state_d == ST_XFER)) gap_d = '0;
    else if (busy && (gap_q != GAP_MAX))             gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  assign track_clr   = (state_q == ST_HELD) && act_start;
  assign track_on    = !mode_level && ((state_q == ST_ACT) || (state_q == ST_XFER));
  assign xfer_req    = (state_q == ST_HELD) || (state_q == ST_ACT);
  assign accept_open = (state_q == ST_OPEN);

  assert_req_from_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(accept_open) && !$past(pin_s));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && !act_start && !abort) |=> xfer_req);

  assert_read_before_act_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && rd_cyc && !act_start && !abort) |=> xfer_req);

  assert_edge_wait_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAITH && !pin_s && !abort) |=> !accept_open);

  assert_clear_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_open && ($past(state_q) == ST_DEAD || $past(state_q) == ST_WAITH))
      |-> gap_q >= GAP_MIN);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!xfer_req && !accept_open));
endmodule

// File: rtl/dreq_accept.sv
module dreq_accept #(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_W       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic xfer_done,
  input  logic mode_level,
  input  logic req_pin_n,
  input  logic act_start,
  input  logic rd_cyc,
  input  logic wr_cyc,
  input  logic dead_cyc,
  output logic xfer_req,
  output logic accept_open
);
  logic pin_s;
  logic hi_seen;
  logic track_clr;
  logic track_on;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_pin_n),
    .d_sync  (pin_s)
  );

  dreq_rearm u_rearm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (track_clr),
    .watch   (track_on),
    .pin_s   (pin_s),
    .hi_seen (hi_seen)
  );

  dreq_fsm #(.GAP_W(GAP_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_set      (en_set),
    .en_clr      (en_clr),
    .xfer_done   (xfer_done),
    .mode_level  (mode_level),
    .pin_s       (pin_s),
    .act_start   (act_start),
    .rd_cyc      (rd_cyc),
    .wr_cyc      (wr_cyc),
    .dead_cyc    (dead_cyc),
    .hi_seen     (hi_seen),
    .track_clr   (track_clr),
    .track_on    (track_on),
    .xfer_req    (xfer_req),
    .accept_open (accept_open)
  );
endmodule

// File: tb/dreq_accept_tb_top.sv
module dreq_accept_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_set = 0, en_clr = 0, xfer_done = 0, mode_level = 0;
  logic req_pin_n = 1, act_start = 0, rd_cyc = 0, wr_cyc = 0, dead_cyc = 0;
  logic xfer_req, accept_open;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  dreq_accept dut_i (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .xfer_done(xfer_done), .mode_level(mode_level), .req_pin_n(req_pin_n),
    .act_start(act_start), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .dead_cyc(dead_cyc),
    .xfer_req(xfer_req), .accept_open(accept_open)
  );

  // Reference model: phase 0 idle, 1 listening, 2 latched, 3 awaiting read,
  // 4 awaiting write, 5 awaiting dead, 6 awaiting a high pin.
  int ph = 0;
  logic hs = 0;
  logic p1 = 1, p2 = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; hs = 0; p1 = 1; p2 = 1;
    end else begin
      if (!mode_level && (ph == 3 || ph == 4) && p2) hs = 1;
      if (en_clr || xfer_done) ph = 0;
      else case (ph)
        0: if (en_set) ph = 1;
        1: if (!p2) ph = 2;
        2: if (act_start) begin ph = 3; hs = 0; end
        3: if (rd_cyc) ph = 4;
        4: if (wr_cyc) ph = 5;
        5: if (dead_cyc) ph = (mode_level || hs) ? 1 : 6;
        6: if (p2) ph = 1;
        default: ph = 0;
      endcase
      p2 = p1; p1 = req_pin_n;
    end
    exp_q.push_back({(ph == 2 || ph == 3), (ph == 1)});
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      n_cmp++;
      if ({xfer_req, accept_open} !== e) begin
        n_bad++;
        $display("FAIL %s: {req,open} actual %b expected %b at %0t", cur_req,
                 {xfer_req, accept_open}, e, $time);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic check_now(input string tag, input logic [1:0] e);
    n_cmp++;
    if ({xfer_req, accept_open} !== e) begin
      n_bad++;
      $display("FAIL %s: {req,open} actual %b expected %b", tag, {xfer_req, accept_open}, e);
    end
  endtask

  initial begin
    step(3);
    check_now("R1", 2'b00);
    rst_n = 1'b1;
    step(3);
    check_now("R1", 2'b00);

    cur_req = "R2";
    req_pin_n = 0; step(4);
    check_now("R2", 2'b00);
    req_pin_n = 1; step(3);
    pulse(en_set);
    check_now("R2", 2'b01);

    cur_req = "R10";
    req_pin_n = 0; step(2);
    check_now("R10", 2'b01);
    step(1);
    check_now("R10", 2'b10);

    cur_req = "R3";
    req_pin_n = 1; step(5);
    check_now("R3", 2'b10);

    cur_req = "R4";
    pulse(rd_cyc); step(2);
    check_now("R4", 2'b10);
    pulse(act_start); step(2);
    pulse(rd_cyc);
    check_now("R4", 2'b00);

    cur_req = "R5";
    step(1); pulse(wr_cyc); step(1); pulse(dead_cyc);
    check_now("R5", 2'b01);

    cur_req = "R6";
    req_pin_n = 0; step(4);
    pulse(act_start); pulse(rd_cyc); pulse(wr_cyc); pulse(dead_cyc);
    step(4);
    check_now("R6", 2'b00);
    req_pin_n = 1; step(2);
    check_now("R6", 2'b00);
    step(1);
    check_now("R6", 2'b01);

    cur_req = "R7";
    mode_level = 1; req_pin_n = 0; step(4);
    pulse(act_start); pulse(rd_cyc);
    cur_req = "R8";
    pulse(wr_cyc);
    check_now("R8", 2'b00);
    pulse(dead_cyc);
    check_now("R7", 2'b01);
    step(1);
    check_now("R7", 2'b10);

    cur_req = "R9";
    pulse(en_clr);
    check_now("R9", 2'b00);
    en_set = 1; en_clr = 1; step(1); en_set = 0; en_clr = 0;
    check_now("R9", 2'b00);
    pulse(en_set); step(2);
    pulse(act_start);
    check_now("R9", 2'b10);
    pulse(xfer_done);
    check_now("R9", 2'b00);
    mode_level = 0; req_pin_n = 1;
    step(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule